// File: doc/BRIEF.md
# Glitch-Free Clock Mode Controller

This block turns one fast master clock into three related clock waveforms: a CPU clock, an early copy of the CPU clock that leads it by one master cycle, and a bus clock. Each is produced by programmable division of the master clock. A two-bit frequency select picks one of four divide ratios. A bus-rate select makes the bus clock either a copy of the CPU clock or half its rate. A doze control halves both the CPU clock and the bus clock.

The block also places the clock outputs in several modes. In stop mode the clocks finish their current high phase and then stay low. In power-down mode generation is switched off and every clock is low. In tristate mode the output-enable is withdrawn. Every control change waits for a point where the CPU clock and the bus clock are both at the end of a low phase, so no output ever shows a shortened phase.

Power-down may only be entered from stop and left back through stop. An illegal request is ignored and raises a sticky sequence-error flag. All clock outputs come straight from registers, so they can drive clock-enable style loads downstream.

Top module: `clk_mode_ctrl`

## Requirements
- R1: With stop_n=1 and doze_n=1, the CPU clock has a half-period of H_SEL[k] master cycles and a 50% duty cycle, where k = ~fsel_n. The defaults are 3, 4, 5 and 6, so fsel_n=11 gives the fastest clock and fsel_n=00 the slowest.
- R2: With bus_half_n=1 the bus clock equals the CPU clock, edge for edge. With bus_half_n=0 its period is twice the CPU period.
- R3: With doze_n=0 the CPU half-period doubles. The bus clock keeps its ratio to the CPU clock, so doze together with a half-rate bus gives a quarter of the selected rate.
- R4: cpu_clk_o always equals ecpu_clk_o delayed by exactly one master cycle.
- R5: No high phase of cpu_clk_o is ever shorter than the smallest H_SEL value. A new frequency, bus rate or doze setting is adopted only when the CPU and bus clocks both end a low phase.
- R6: With stop_n=0 and {bus_half_n,doze_n} equal to 01 or 11 (stop), the clocks complete their current high phase and then stay low. clk_oe_o stays 1.
- R7: With stop_n=0 and {bus_half_n,doze_n}=10 (tristate), clk_oe_o is 0 and all clocks are low.
- R8: With stop_n=0 and {bus_half_n,doze_n}=00 (power-down), requested while in stop, pwr_down_o becomes 1, the clocks stay low and no error is flagged.
- R9: While powered down, only a stop request is accepted and clears pwr_down_o. Any other request is ignored: the block stays powered down with the clocks low, and seq_err_o is set.
- R10: A power-down request made while running or in tristate is ignored: the current mode and the clocks carry on, and seq_err_o is set.
- R11: Once set, seq_err_o stays 1 until reset.
- R12: While reset is held and after it is released, the block is in stop mode: all clocks are 0, clk_oe_o is 1, pwr_down_o is 0 and seq_err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsel_n | input | 2 | Frequency select, active low (index = ~fsel_n) |
| bus_half_n | input | 1 | Low: bus at half the CPU rate; high: bus equals CPU |
| doze_n | input | 1 | Low: halve CPU and bus rates |
| stop_n | input | 1 | Low: stop, tristate or power-down, chosen by bus_half_n and doze_n |
| cpu_clk_o | output | 1 | CPU clock waveform |
| ecpu_clk_o | output | 1 | Early CPU clock, one master cycle ahead |
| bus_clk_o | output | 1 | Bus clock waveform |
| clk_oe_o | output | 1 | Output enable; 0 in tristate mode |
| pwr_down_o | output | 1 | Generation powered down |
| seq_err_o | output | 1 | Sticky illegal power-down sequencing flag |

## Verification
The divider is driven with eight select patterns that cover every frequency code, both bus ratios and doze on and off, including the quarter-rate combination. Measuring period and high time for each pattern separates a wrong table lookup from a wrong bus ratio or a missing doze doubling. The patterns are applied back to back while the clocks run, so a runt phase would show up if a setting were adopted mid-phase. The mode tests then walk the legal stop, power-down and stop sequence, and also try direct entry into and exit from power-down. Together these show that an ignored request leaves the clocks in their previous state while still latching the error.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

  typedef enum logic [1:0] {M_RUN, M_STOP, M_PDOWN, M_TRI} mode_e;

  // Mode requested by the control pins.
  function automatic mode_e decode_req(logic stop_n, logic bus_half_n, logic doze_n);
    if (stop_n) return M_RUN;
    case ({bus_half_n, doze_n})
      2'b00:   return M_PDOWN;
      2'b10:   return M_TRI;
      default: return M_STOP;
    endcase
  endfunction

  // Half-period in master cycles for a select index and doze state.
  function automatic int unsigned half_len(logic [1:0] sel, logic dozing,
                                           int unsigned h0, int unsigned h1,
                                           int unsigned h2, int unsigned h3);
    int unsigned b;
    case (sel)
      2'd0:    b = h0;
      2'd1:    b = h1;
      2'd2:    b = h2;
      default: b = h3;
    endcase
    return dozing ? 2 * b : b;
  endfunction

  // A move into power-down needs stop; a move out of power-down must go to stop.
  function automatic logic legal_move(mode_e cur, mode_e req);
    if (req == M_PDOWN) return (cur == M_STOP) || (cur == M_PDOWN);
    if (cur == M_PDOWN) return req == M_STOP;
    return 1'b1;
  endfunction

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int unsigned min4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b < m) m = b;
    if (c < m) m = c;
    if (d < m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/clk_mode_fsm.sv
module clk_mode_fsm
  import clk_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_i,
  input  mode_e req_i,
  output mode_e mode_o,
  output mode_e mode_nxt_o,
  output logic  err_o
);

  mode_e mode_q;
  logic  err_q;
  logic  legal_w;

  assign legal_w    = legal_move(mode_q, req_i);
  assign mode_nxt_o = legal_w ? req_i : mode_q;
  assign mode_o     = mode_q;
  assign err_o      = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_STOP;
      err_q  <= 1'b0;
    end else if (step_i) begin
      mode_q <= mode_nxt_o;
      if (!legal_w) err_q <= 1'b1;
    end
  end

  // R8: power-down is only reached from stop
  p_pd_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PDOWN && $past(mode_q) != M_PDOWN) |-> $past(mode_q) == M_STOP);

  // R9: power-down is only left towards stop
  p_pd_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == M_PDOWN && mode_q != M_PDOWN) |-> mode_q == M_STOP);

  // R11: the error flag never clears
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_q) |-> err_q);

endmodule

// File: rtl/clk_div_gen.sv
module clk_div_gen #(
  parameter int unsigned CW   = 4,
  parameter int unsigned HMIN = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] half_i,
  input  logic          full_i,
  input  logic          run_i,
  output logic          ecpu_o,
  output logic          ebus_o,
  output logic          step_o
);

  localparam logic [CW:0] HMIN_V = (CW+1)'(HMIN);

  logic [CW-1:0] cnt_q, half_q;
  logic          full_q, cpu_q, bus_q;

  // Step point: end of a low phase on both clocks.
  assign step_o = (cnt_q == '0) && !cpu_q && !bus_q;
  assign ecpu_o = cpu_q;
  assign ebus_o = bus_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= CW'(1);
      full_q <= 1'b1;
      cpu_q  <= 1'b0;
      bus_q  <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end else if (cpu_q) begin
      cpu_q <= 1'b0;
      if (full_q) bus_q <= 1'b0;
      cnt_q <= half_q - CW'(1);
    end else if (bus_q) begin
      // half-rate bus: CPU rises while bus falls, not a step point
      cpu_q <= 1'b1;
      bus_q <= 1'b0;
      cnt_q <= half_q - CW'(1);
    end else begin
      half_q <= half_i;
      full_q <= full_i;
      if (run_i) begin
        cpu_q <= 1'b1;
        bus_q <= 1'b1;
        cnt_q <= half_i - CW'(1);
      end
    end
  end

  // high-phase length tracker for the runt check
  logic [CW:0] hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_len <= '0;
    else        hi_len <= cpu_q ? hi_len + (CW+1)'(1) : '0;
  end

  // R5: a completed high phase is never shorter than the shortest half-period
  p_no_runt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_len != '0 && !cpu_q) |-> hi_len >= HMIN_V);

endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clk_mode_pkg::*;
#(
  parameter int unsigned H_SEL0 = 3,
  parameter int unsigned H_SEL1 = 4,
  parameter int unsigned H_SEL2 = 5,
  parameter int unsigned H_SEL3 = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] fsel_n,
  input  logic       bus_half_n,
  input  logic       doze_n,
  input  logic       stop_n,
  output logic       cpu_clk_o,
  output logic       ecpu_clk_o,
  output logic       bus_clk_o,
  output logic       clk_oe_o,
  output logic       pwr_down_o,
  output logic       seq_err_o
);

  localparam int unsigned HMAX = max4(H_SEL0, H_SEL1, H_SEL2, H_SEL3);
  localparam int unsigned HMIN = min4(H_SEL0, H_SEL1, H_SEL2, H_SEL3);
  localparam int unsigned CW   = $clog2(2 * HMAX + 1);

  mode_e         req_w, mode_w, mode_nxt_w;
  logic          step_w, ecpu_w, ebus_w, run_w;
  logic [CW-1:0] half_w;

  assign req_w  = decode_req(stop_n, bus_half_n, doze_n);
  assign half_w = CW'(half_len(~fsel_n, ~doze_n, H_SEL0, H_SEL1, H_SEL2, H_SEL3));
  assign run_w  = (mode_nxt_w == M_RUN);

  clk_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step_w),
    .req_i      (req_w),
    .mode_o     (mode_w),
    .mode_nxt_o (mode_nxt_w),
    .err_o      (seq_err_o)
  );

  clk_div_gen #(.CW(CW), .HMIN(HMIN)) u_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .half_i (half_w),
    .full_i (bus_half_n),
    .run_i  (run_w),
    .ecpu_o (ecpu_w),
    .ebus_o (ebus_w),
    .step_o (step_w)
  );

  // One register stage puts the CPU and bus clocks behind the early copy.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_clk_o <= 1'b0;
      bus_clk_o <= 1'b0;
      clk_oe_o  <= 1'b1;
    end else begin
      cpu_clk_o <= ecpu_w;
      bus_clk_o <= ebus_w;
      clk_oe_o  <= (mode_w != M_TRI);
    end
  end

  assign ecpu_clk_o = ecpu_w;
  assign pwr_down_o = (mode_w == M_PDOWN);

  // R6: outside run mode the generator holds both clocks low
  p_halt_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w != M_RUN) |-> (!ecpu_w && !ebus_w));

  // R7: withdrawn enable never coincides with a high clock
  p_quiet_tri_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_oe_o |-> (!cpu_clk_o && !bus_clk_o));

endmodule

// File: tb/tb_clk_mode_ctrl.sv
module tb_clk_mode_ctrl;

  logic       clk, rst_n;
  logic [1:0] fsel_n;
  logic       bus_half_n, doze_n, stop_n;
  logic       cpu_clk_o, ecpu_clk_o, bus_clk_o, clk_oe_o, pwr_down_o, seq_err_o;

  int checks = 0;
  int fails  = 0;

  clk_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .fsel_n(fsel_n), .bus_half_n(bus_half_n),
    .doze_n(doze_n), .stop_n(stop_n), .cpu_clk_o(cpu_clk_o),
    .ecpu_clk_o(ecpu_clk_o), .bus_clk_o(bus_clk_o), .clk_oe_o(clk_oe_o),
    .pwr_down_o(pwr_down_o), .seq_err_o(seq_err_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {fsel_n[1:0], bus_half_n, doze_n, cpu period[7:0], bus period[7:0]}
  localparam logic [19:0] VEC [8] = '{
    {2'b11, 1'b1, 1'b1, 8'd6,  8'd6 },
    {2'b11, 1'b0, 1'b1, 8'd6,  8'd12},
    {2'b10, 1'b1, 1'b1, 8'd8,  8'd8 },
    {2'b01, 1'b0, 1'b1, 8'd10, 8'd20},
    {2'b00, 1'b1, 1'b1, 8'd12, 8'd12},
    {2'b11, 1'b0, 1'b0, 8'd12, 8'd24},
    {2'b00, 1'b0, 1'b0, 8'd24, 8'd48},
    {2'b10, 1'b1, 1'b0, 8'd16, 8'd16}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pins(input logic s, input logic bh, input logic dz);
    @(negedge clk);
    stop_n = s; bus_half_n = bh; doze_n = dz;
  endtask

  function automatic logic pick(input int which);
    return (which == 0) ? cpu_clk_o : bus_clk_o;
  endfunction

  // period and high time between two rising edges, sampled at falling master edges
  task automatic meas(input int which, output int per, output int hi);
    logic p, c;
    @(negedge clk); p = pick(which);
    forever begin
      @(negedge clk); c = pick(which);
      if (c && !p) break;
      p = c;
    end
    per = 0; hi = 0; p = c;
    forever begin
      hi += int'(c); per++;
      @(negedge clk); c = pick(which);
      if (c && !p) break;
      p = c;
    end
  endtask

  // R4 lead and (optionally) R2 equality over a window
  task automatic lead_window(input logic bus_eq);
    int bad_lead = 0, bad_eq = 0;
    logic prev_e;
    @(negedge clk); prev_e = ecpu_clk_o;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (cpu_clk_o !== prev_e) bad_lead++;
      if (bus_eq && bus_clk_o !== cpu_clk_o) bad_eq++;
      prev_e = ecpu_clk_o;
    end
    chk("R4 early clock lead mismatches", bad_lead, 0);
    if (bus_eq) chk("R2 full-rate bus mismatches", bad_eq, 0);
  endtask

  // count high samples on all clocks over a window
  task automatic quiet_window(input string tag, input int n);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      highs += int'(cpu_clk_o) + int'(ecpu_clk_o) + int'(bus_clk_o);
    end
    chk(tag, highs, 0);
  endtask

  // runt monitor on cpu_clk_o high phases (R5)
  int hi_run = 0, min_hi = 1000;
  always @(negedge clk) begin
    if (cpu_clk_o) hi_run++;
    else begin
      if (hi_run != 0 && hi_run < min_hi) min_hi = hi_run;
      hi_run = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int per, hi;
    rst_n = 1'b0; fsel_n = 2'b11; stop_n = 1'b0; bus_half_n = 1'b0; doze_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 cpu in reset", int'(cpu_clk_o), 0);
    chk("R12 oe in reset", int'(clk_oe_o), 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R12 clocks after reset", int'(cpu_clk_o | ecpu_clk_o | bus_clk_o), 0);
    chk("R12 oe after reset", int'(clk_oe_o), 1);
    chk("R12 pd after reset", int'(pwr_down_o), 0);
    chk("R12 err after reset", int'(seq_err_o), 0);

    // table walk: R1 R2 R3, switching while running (R5)
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      fsel_n = VEC[v][19:18]; bus_half_n = VEC[v][17]; doze_n = VEC[v][16]; stop_n = 1'b1;
      repeat (120) @(negedge clk);
      meas(0, per, hi);
      chk($sformatf("R1/R3 cpu period vec%0d", v), per, int'(VEC[v][15:8]));
      chk($sformatf("R1 cpu high time vec%0d", v), hi, int'(VEC[v][15:8]) / 2);
      meas(1, per, hi);
      chk($sformatf("R2/R3 bus period vec%0d", v), per, int'(VEC[v][7:0]));
      lead_window(VEC[v][17]);
    end

    // R6 stop
    pins(1'b0, 1'b1, 1'b1);
    repeat (60) @(negedge clk);
    quiet_window("R6 clocks low in stop", 50);
    chk("R6 oe in stop", int'(clk_oe_o), 1);
    // R7 tristate
    pins(1'b0, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    chk("R7 oe in tristate", int'(clk_oe_o), 0);
    quiet_window("R7 clocks low in tristate", 20);
    // R8 legal entry through stop
    pins(1'b0, 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    chk("R7 oe back on in stop", int'(clk_oe_o), 1);
    pins(1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk("R8 pd entered from stop", int'(pwr_down_o), 1);
    chk("R8 no error on legal entry", int'(seq_err_o), 0);
    quiet_window("R8 clocks low in power-down", 20);
    // R9 legal exit
    pins(1'b0, 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    chk("R9 pd left through stop", int'(pwr_down_o), 0);
    fsel_n = 2'b11;
    pins(1'b1, 1'b1, 1'b1);
    repeat (30) @(negedge clk);
    meas(0, per, hi);
    chk("R9 clocks resume after legal exit", per, 6);
    chk("R9 no error on legal exit", int'(seq_err_o), 0);

    // R10 illegal entry from run: clocks go on (doze and half bus pins now low)
    pins(1'b0, 1'b0, 1'b0);
    repeat (60) @(negedge clk);
    chk("R10 pd ignored from run", int'(pwr_down_o), 0);
    chk("R10 error raised", int'(seq_err_o), 1);
    meas(0, per, hi);
    chk("R10 cpu keeps running", per, 12);
    pins(1'b1, 1'b1, 1'b1);
    repeat (50) @(negedge clk);
    chk("R11 error sticky", int'(seq_err_o), 1);

    // R9 illegal exit
    pins(1'b0, 1'b0, 1'b1);
    repeat (60) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 error cleared by reset", int'(seq_err_o), 0);
    pins(1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk("R8 pd entered again", int'(pwr_down_o), 1);
    pins(1'b1, 1'b1, 1'b1);
    repeat (10) @(negedge clk);
    chk("R9 pd held on run request", int'(pwr_down_o), 1);
    chk("R9 error on illegal exit", int'(seq_err_o), 1);
    quiet_window("R9 clocks low after illegal exit", 30);
    pins(1'b0, 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    chk("R9 stop accepted after illegal try", int'(pwr_down_o), 0);
    pins(1'b1, 1'b1, 1'b1);
    repeat (30) @(negedge clk);
    meas(0, per, hi);
    chk("R9 clocks resume", per, 6);
    chk("R11 error still set", int'(seq_err_o), 1);

    // R10 illegal entry from tristate
    pins(1'b0, 1'b1, 1'b0);
    repeat (60) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pins(1'b0, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    pins(1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk("R10 pd ignored from tristate", int'(pwr_down_o), 0);
    chk("R10 tristate kept", int'(clk_oe_o), 0);
    chk("R10 error from tristate", int'(seq_err_o), 1);

    chk("R5 shortest cpu high phase", (min_hi >= 3) ? 1 : 0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule